// File: doc/BRIEF.md
# Flagged-Byte Vector Lane ALU

This block is the arithmetic slice of a vector lane whose storage unit is a 9-bit byte: eight data bits plus one flag bit. Each beat carries `4*WORDS` such bytes. The beat is split into byte, halfword or word elements. Each element is added or subtracted, as signed or unsigned. The data bits of the result hold the sum or difference. The flag bit of the element's top byte records the condition that a later instruction will test: the carry or borrow for unsigned operations, and the sign of the exact result for signed ones.

The same datapath also performs a predicated move. It copies the first operand into the destination only where the flag in the top byte of the matching element of the second operand is set. Elements that are not selected are left alone, which the block expresses through per-byte write enables and not through a read-modify-write. This lets two instructions clamp a vector to a limit: subtract the data from the limit, then move the limit where the subtraction borrowed. The first operand can be replaced by a scalar broadcast to every element. The second operand can be replaced by the element's position index counted from a supplied base.

The results are registered and appear two cycles after the beat is accepted, with one beat accepted per cycle.

Top module: `flag_lane_alu`

## Requirements
- R1: A beat accepted with `valid_i` high in one cycle comes out with `valid_o` high exactly two clock cycles later, with one result per accepted beat. Whenever `valid_o` is low, `we_o` is all zero. After reset, `valid_o`, `we_o` and `res_o` are zero.
- R2: Operation code 0 (unsigned add) puts the low bits of A+B into the element's data bits. The carry out of the element goes into the flag bit of its most significant byte.
- R3: Operation code 1 (unsigned subtract) puts A−B modulo 2^n into the data bits. The flag of the most significant byte is 1 exactly when A < B, which is the borrow.
- R4: Operation codes 2 (signed add) and 3 (signed subtract) put the wrapped result into the data bits. The flag of the most significant byte holds the sign of the exact, unwrapped result, so it is correct even when the sum overflows.
- R5: The size code 0 selects byte elements, 1 selects halfwords, and 2 or 3 select words. No carry crosses an element boundary. For halfword and word arithmetic, the flag bits of the bytes other than the element's top byte are written as 0.
- R6: For operation codes 0 to 3, all bytes of a valid result have their write enable set.
- R7: Operation code 4 (conditional move on less-than-zero) outputs the A operand's bytes, flags included. It sets the write enables of all bytes of an element to the flag bit of the top byte of the corresponding B element, so all bytes of an element share one enable.
- R8: With `bcast_a_i` set, each element's A operand is the low element-width bits of `scalar_i`, with all of its flag bits 0.
- R9: With `enum_b_i` set, each element's B operand is `base_idx_i` plus the element's position within the beat (0, 1, 2, …). This value is truncated to the element width and its flag bits are 0, so a conditional move on an enumerated predicate writes nothing.
- R10: Operation codes 5, 6 and 7 produce a valid beat with all write enables clear and a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Beat present on the inputs this cycle |
| op_i | input | 3 | Operation code (0 addu, 1 subu, 2 adds, 3 subs, 4 conditional move) |
| size_i | input | 2 | Element size (0 byte, 1 halfword, 2/3 word) |
| bcast_a_i | input | 1 | Replace A with the broadcast scalar |
| enum_b_i | input | 1 | Replace B with the enumerated element index |
| scalar_i | input | 32 | Scalar value for broadcast |
| base_idx_i | input | IDXW | Index of the first element in this beat |
| a_i | input | 9*4*WORDS | Operand A; byte k at bits [9k+8:9k], flag at bit 9k+8 |
| b_i | input | 9*4*WORDS | Operand B (also the predicate), same layout |
| valid_o | output | 1 | Result beat present |
| res_o | output | 9*4*WORDS | Result bytes, same layout |
| we_o | output | 4*WORDS | Per-byte write enable for the result |

## Verification
The embedded assertions are checked on every clock cycle. They cover the two-cycle valid pipeline and the enables that stay quiet when nothing is valid. They also check that arithmetic always writes every byte, that undefined codes write nothing, that each element of a conditional move shares one enable, and that the lower flag bits are cleared on word arithmetic. Only the bench scenarios can show that the numbers are right. This covers carries and borrows at each element size and signed overflow cases whose flag differs from the wrapped sign bit. It also covers broadcast and enumeration substitution, and the two-step clamp of unsigned bytes to a limit.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  localparam logic [2:0] OP_ADDU = 3'd0;
  localparam logic [2:0] OP_SUBU = 3'd1;
  localparam logic [2:0] OP_ADDS = 3'd2;
  localparam logic [2:0] OP_SUBS = 3'd3;
  localparam logic [2:0] OP_CMV  = 3'd4;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2
  } esize_e;

  function automatic esize_e norm_size(input logic [1:0] code);
    case (code)
      2'd0:    return SZ_B;
      2'd1:    return SZ_H;
      default: return SZ_W;
    endcase
  endfunction

  function automatic logic is_arith(input logic [2:0] op);
    return (op <= OP_SUBS);
  endfunction

endpackage

// File: rtl/lane_opsel.sv
module lane_opsel
  import lane_alu_pkg::*;
#(
  parameter int NB   = 8,
  parameter int IDXW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              bcast_i,
  input  logic              enum_i,
  input  logic [31:0]       scalar_i,
  input  logic [IDXW-1:0]   base_i,
  input  logic [9*NB-1:0]   a_i,
  input  logic [9*NB-1:0]   b_i,
  output logic              vld_q,
  output logic [2:0]        op_q,
  output esize_e            sz_q,
  output logic [9*NB-1:0]   a_q,
  output logic [9*NB-1:0]   b_q
);

  localparam int DW = 9 * NB;

  esize_e          sz_n;
  logic [DW-1:0]   a_sel;
  logic [DW-1:0]   b_sel;

  assign sz_n = norm_size(size_i);

  always_comb begin
    a_sel = a_i;
    b_sel = b_i;
    for (int k = 0; k < NB; k++) begin
      int              j;
      int              elem;
      logic [IDXW-1:0] idx;
      logic [IDXW-1:0] sh;
      case (sz_n)
        SZ_B:    begin j = 0;     elem = k;      end
        SZ_H:    begin j = k % 2; elem = k >> 1; end
        default: begin j = k % 4; elem = k >> 2; end
      endcase
      idx = base_i + IDXW'(elem);
      sh  = idx >> (8 * j);
      if (bcast_i) a_sel[9*k +: 9] = {1'b0, scalar_i[8*j +: 8]};
      if (enum_i)  b_sel[9*k +: 9] = {1'b0, sh[7:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      op_q  <= 3'd0;
      sz_q  <= SZ_B;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      vld_q <= vld_i;
      op_q  <= op_i;
      sz_q  <= sz_n;
      a_q   <= a_sel;
      b_q   <= b_sel;
    end
  end

  // R1
  stage1_vld_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> $past(vld_i));

endmodule

// File: rtl/lane_word_alu.sv
module lane_word_alu
  import lane_alu_pkg::*;
(
  input  logic [35:0] a_i,
  input  logic [35:0] b_i,
  input  logic [2:0]  op_i,
  input  esize_e      sz_i,
  output logic [35:0] r_o,
  output logic [3:0]  we_o
);

  logic sub;
  logic sgn;

  assign sub = (op_i == OP_SUBU) || (op_i == OP_SUBS);
  assign sgn = (op_i == OP_ADDS) || (op_i == OP_SUBS);

  always_comb begin
    logic c;
    r_o  = '0;
    we_o = '0;
    c    = sub;
    for (int k = 0; k < 4; k++) begin
      logic       start;
      logic       top;
      logic [7:0] av;
      logic [7:0] bx;
      logic [8:0] s9;
      logic       fl;
      int         m;
      start = (k == 0) || (sz_i == SZ_B) || (sz_i == SZ_H && k == 2);
      top   = (k == 3) || (sz_i == SZ_B) || (sz_i == SZ_H && k == 1);
      if (start) c = sub;
      av = a_i[9*k +: 8];
      bx = sub ? ~b_i[9*k +: 8] : b_i[9*k +: 8];
      s9 = {1'b0, av} + {1'b0, bx} + {8'd0, c};
      if (sgn)      fl = av[7] ^ bx[7] ^ s9[8];
      else if (sub) fl = ~s9[8];
      else          fl = s9[8];
      c = s9[8];
      case (sz_i)
        SZ_B:    m = k;
        SZ_H:    m = k | 1;
        default: m = 3;
      endcase
      if (is_arith(op_i)) begin
        r_o[9*k +: 9] = {top ? fl : 1'b0, s9[7:0]};
        we_o[k]       = 1'b1;
      end else if (op_i == OP_CMV) begin
        r_o[9*k +: 9] = a_i[9*k +: 9];
        we_o[k]       = b_i[9*m + 8];
      end
    end
  end

endmodule

// File: rtl/flag_lane_alu.sv
module flag_lane_alu
  import lane_alu_pkg::*;
#(
  parameter int WORDS = 2,
  parameter int IDXW  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic [2:0]           op_i,
  input  logic [1:0]           size_i,
  input  logic                 bcast_a_i,
  input  logic                 enum_b_i,
  input  logic [31:0]          scalar_i,
  input  logic [IDXW-1:0]      base_idx_i,
  input  logic [9*4*WORDS-1:0] a_i,
  input  logic [9*4*WORDS-1:0] b_i,
  output logic                 valid_o,
  output logic [9*4*WORDS-1:0] res_o,
  output logic [4*WORDS-1:0]   we_o
);

  localparam int NB = 4 * WORDS;
  localparam int DW = 9 * NB;

  logic          s1_vld;
  logic [2:0]    s1_op;
  esize_e        s1_sz;
  logic [DW-1:0] s1_a;
  logic [DW-1:0] s1_b;
  logic [DW-1:0] alu_r;
  logic [NB-1:0] alu_we;
  logic [2:0]    op_q2;
  esize_e        sz_q2;

  lane_opsel #(.NB(NB), .IDXW(IDXW)) u_opsel (
    .clk      (clk),
    .rst      (rst),
    .vld_i    (valid_i),
    .op_i     (op_i),
    .size_i   (size_i),
    .bcast_i  (bcast_a_i),
    .enum_i   (enum_b_i),
    .scalar_i (scalar_i),
    .base_i   (base_idx_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .vld_q    (s1_vld),
    .op_q     (s1_op),
    .sz_q     (s1_sz),
    .a_q      (s1_a),
    .b_q      (s1_b)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    lane_word_alu u_alu (
      .a_i  (s1_a[36*w +: 36]),
      .b_i  (s1_b[36*w +: 36]),
      .op_i (s1_op),
      .sz_i (s1_sz),
      .r_o  (alu_r[36*w +: 36]),
      .we_o (alu_we[4*w +: 4])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      we_o    <= '0;
      op_q2   <= 3'd0;
      sz_q2   <= SZ_B;
    end else begin
      valid_o <= s1_vld;
      res_o   <= alu_r;
      we_o    <= s1_vld ? alu_we : '0;
      op_q2   <= s1_op;
      sz_q2   <= s1_sz;
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(valid_i, 2));

  // R1
  idle_we_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (we_o == '0));

  // R6
  arith_we_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && is_arith(op_q2)) |-> (&we_o));

  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && op_q2 > OP_CMV) |-> (we_o == '0));

  for (genvar w = 0; w < WORDS; w++) begin : g_chk
    // R5
    low_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_o && is_arith(op_q2) && sz_q2 == SZ_W) |->
        (res_o[36*w + 8] == 1'b0 && res_o[36*w + 17] == 1'b0 && res_o[36*w + 26] == 1'b0));

    // R7
    cmv_uniform_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_o && op_q2 == OP_CMV && sz_q2 == SZ_W) |->
        (we_o[4*w +: 4] == 4'h0 || we_o[4*w +: 4] == 4'hF));
  end

endmodule

// File: tb/tb_flag_lane_alu.sv
`timescale 1ns/1ps
module tb_flag_lane_alu;

  localparam int WORDS = 2;
  localparam int NB    = 4 * WORDS;
  localparam int DW    = 9 * NB;

  logic          clk = 1'b0;
  logic          rst;
  logic          valid_i;
  logic [2:0]    op_i;
  logic [1:0]    size_i;
  logic          bcast_a_i;
  logic          enum_b_i;
  logic [31:0]   scalar_i;
  logic [31:0]   base_idx_i;
  logic [DW-1:0] a_i;
  logic [DW-1:0] b_i;
  logic          valid_o;
  logic [DW-1:0] res_o;
  logic [NB-1:0] we_o;

  always #4 clk = ~clk;

  flag_lane_alu #(.WORDS(WORDS), .IDXW(32)) dut (
    .clk, .rst, .valid_i, .op_i, .size_i, .bcast_a_i, .enum_b_i,
    .scalar_i, .base_idx_i, .a_i, .b_i, .valid_o, .res_o, .we_o
  );

  typedef struct {
    logic [DW-1:0] res;
    logic [NB-1:0] we;
    int            cyc;
    string         req;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void model(
    input  logic [2:0]    op, input logic [1:0] sz, input logic bc, input logic en,
    input  logic [31:0]   sc, input logic [31:0] base,
    input  logic [DW-1:0] a,  input logic [DW-1:0] b,
    output logic [DW-1:0] r,  output logic [NB-1:0] we);
    int esz;
    int nbits;
    esz   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    nbits = 8 * esz;
    r  = '0;
    we = '0;
    for (int e = 0; e < NB / esz; e++) begin
      longint      av;
      longint      bv;
      longint      half;
      longint      rs;
      logic        fl;
      logic        p;
      logic [31:0] idx;
      logic [8:0]  ab [4];
      av   = 0;
      bv   = 0;
      idx  = base + e;
      half = longint'(1) << (nbits - 1);
      for (int j = 0; j < esz; j++) begin
        logic [8:0] bb;
        ab[j] = bc ? {1'b0, sc[8*j +: 8]} : a[9*(e*esz+j) +: 9];
        bb    = en ? {1'b0, idx[8*j +: 8]} : b[9*(e*esz+j) +: 9];
        av = av | (longint'(ab[j][7:0]) << (8*j));
        bv = bv | (longint'(bb[7:0]) << (8*j));
      end
      p = en ? 1'b0 : b[9*(e*esz+esz-1) + 8];
      rs = 0;
      fl = 1'b0;
      case (op)
        3'd0: begin rs = av + bv; fl = ((rs >> nbits) & 1) != 0; end
        3'd1: begin rs = av - bv; fl = (av < bv); end
        3'd2: begin rs = ((av ^ half) - half) + ((bv ^ half) - half); fl = (rs < 0); end
        3'd3: begin rs = ((av ^ half) - half) - ((bv ^ half) - half); fl = (rs < 0); end
        default: ;
      endcase
      for (int j = 0; j < esz; j++) begin
        int k;
        k = e * esz + j;
        if (op <= 3'd3) begin
          r[9*k +: 9] = {(j == esz - 1) ? fl : 1'b0, 8'(rs >> (8*j))};
          we[k] = 1'b1;
        end else if (op == 3'd4) begin
          r[9*k +: 9] = ab[j];
          we[k] = p;
        end
      end
    end
  endfunction

  task automatic drive(input logic [2:0] op, input logic [1:0] sz, input logic bc,
                       input logic en, input logic [31:0] sc, input logic [31:0] base,
                       input logic [DW-1:0] a, input logic [DW-1:0] b, input string req);
    item_t it;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; size_i = sz; bcast_a_i = bc; enum_b_i = en;
    scalar_i = sc; base_idx_i = base; a_i = a; b_i = b;
    model(op, sz, bc, en, sc, base, a, b, it.res, it.we);
    it.cyc = cyc;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  function automatic logic [DW-1:0] pack8(input logic [8:0] v [NB]);
    logic [DW-1:0] x;
    for (int k = 0; k < NB; k++) x[9*k +: 9] = v[k];
    return x;
  endfunction

  function automatic logic [DW-1:0] rnd();
    return DW'({$urandom, $urandom, $urandom});
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R1: unexpected valid_o, got res=%h expected no beat", res_o);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (cyc != it.cyc + 2) begin
          bad++;
          $display("FAIL R1: latency got %0d expected 2", cyc - it.cyc);
        end
        if (res_o !== it.res || we_o !== it.we) begin
          bad++;
          $display("FAIL %s: got res=%h we=%b expected res=%h we=%b",
                   it.req, res_o, we_o, it.res, it.we);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [8:0]    v [NB];
    logic [DW-1:0] s1r;
    logic [NB-1:0] s1w;
    logic [DW-1:0] dat;
    rst = 1'b1; valid_i = 1'b0; op_i = '0; size_i = '0; bcast_a_i = 1'b0;
    enum_b_i = 1'b0; scalar_i = '0; base_idx_i = '0; a_i = '0; b_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (valid_o !== 1'b0 || we_o !== '0 || res_o !== '0) begin
      bad++;
      $display("FAIL R1: reset state got v=%b we=%b expected 0 0", valid_o, we_o);
    end

    // R2 byte carries, halfword carry across byte, word add
    v = '{9'h0FF, 9'h080, 9'h001, 9'h07F, 9'h0AA, 9'h000, 9'h0FE, 9'h010};
    dat = pack8(v);
    v = '{9'h001, 9'h080, 9'h0FF, 9'h001, 9'h055, 9'h000, 9'h003, 9'h0F0};
    drive(3'd0, 2'd0, 0, 0, 0, 0, dat, pack8(v), "R2");
    drive(3'd0, 2'd1, 0, 0, 0, 0, dat, pack8(v), "R2");
    drive(3'd0, 2'd2, 0, 0, 0, 0, dat, pack8(v), "R2");
    // R3 borrows at each size
    drive(3'd1, 2'd0, 0, 0, 0, 0, dat, pack8(v), "R3");
    drive(3'd1, 2'd1, 0, 0, 0, 0, pack8(v), dat, "R3");
    drive(3'd1, 2'd2, 0, 0, 0, 0, dat, pack8(v), "R3");
    // R4 signed overflow: 0x7F+0x01, 0x80-0x01, halfword 0x8000-0x0001
    v = '{9'h07F, 9'h080, 9'h000, 9'h080, 9'h07F, 9'h0FF, 9'h000, 9'h080};
    dat = pack8(v);
    v = '{9'h001, 9'h001, 9'h001, 9'h0FF, 9'h0FF, 9'h001, 9'h001, 9'h000};
    drive(3'd2, 2'd0, 0, 0, 0, 0, dat, pack8(v), "R4");
    drive(3'd3, 2'd0, 0, 0, 0, 0, dat, pack8(v), "R4");
    drive(3'd3, 2'd1, 0, 0, 0, 0, dat, pack8(v), "R4");
    drive(3'd2, 2'd2, 0, 0, 0, 0, dat, pack8(v), "R4");
    // R5 size code 3 behaves as word, input flags must not leak
    drive(3'd0, 2'd3, 0, 0, 0, 0, {DW{1'b1}}, {DW{1'b1}}, "R5");
    drive(3'd1, 2'd1, 0, 0, 0, 0, {DW{1'b1}}, '0, "R5");
    // R7 conditional move, mixed predicates at each size
    v = '{9'h100, 9'h000, 9'h100, 9'h100, 9'h000, 9'h100, 9'h000, 9'h000};
    drive(3'd4, 2'd0, 0, 0, 0, 0, rnd(), pack8(v), "R7");
    drive(3'd4, 2'd1, 0, 0, 0, 0, rnd(), pack8(v), "R7");
    drive(3'd4, 2'd2, 0, 0, 0, 0, rnd(), pack8(v), "R7");
    // R8 broadcast scalar
    drive(3'd0, 2'd0, 1, 0, 32'hDEADBE01, 0, rnd(), rnd(), "R8");
    drive(3'd1, 2'd2, 1, 0, 32'h00000000, 0, rnd(), rnd(), "R8");
    drive(3'd4, 2'd1, 1, 0, 32'h1234ABCD, 0, rnd(), {DW{1'b1}}, "R8");
    // R9 enumerated index
    drive(3'd0, 2'd0, 0, 1, 0, 32'd250, '0, rnd(), "R9");
    drive(3'd0, 2'd1, 0, 1, 0, 32'h0000FFFF, '0, rnd(), "R9");
    drive(3'd2, 2'd2, 0, 1, 0, 32'h7FFFFFFF, rnd(), rnd(), "R9");
    drive(3'd4, 2'd0, 0, 1, 0, 32'd3, rnd(), {DW{1'b1}}, "R9");
    // R10 undefined codes
    drive(3'd5, 2'd0, 0, 0, 0, 0, rnd(), rnd(), "R10");
    drive(3'd6, 2'd1, 1, 1, 7, 9, rnd(), rnd(), "R10");
    drive(3'd7, 2'd2, 0, 0, 0, 0, rnd(), {DW{1'b1}}, "R10");
    idle();
    // R3 and R7: clamp unsigned bytes to 100 in two steps
    v = '{9'd5, 9'd100, 9'd101, 9'd200, 9'd0, 9'd255, 9'd99, 9'd150};
    dat = pack8(v);
    drive(3'd1, 2'd0, 1, 0, 32'd100, 0, '0, dat, "R3");
    model(3'd1, 2'd0, 1, 0, 32'd100, 0, '0, dat, s1r, s1w);
    drive(3'd4, 2'd0, 1, 0, 32'd100, 0, '0, s1r, "R7");
    idle();
    idle();
    // Mixed random traffic, back to back
    for (int n = 0; n < 80; n++) begin
      logic [2:0] op;
      string      tag;
      op = 3'($urandom_range(0, 7));
      case (op)
        3'd0: tag = "R2";
        3'd1: tag = "R3";
        3'd2, 3'd3: tag = "R4";
        3'd4: tag = "R7";
        default: tag = "R10";
      endcase
      drive(op, 2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 3) == 0), $urandom, $urandom, rnd(), rnd(), tag);
      if ($urandom_range(0, 4) == 0) idle();
    end
    idle();
    repeat (6) @(negedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R1: missing results got %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule